// File: doc/BRIEF.md
# Forward ECP Command and Run-Length Decoder

This block sits on the receive side of a parallel-port peripheral running in the extended bidirectional mode. Each byte reaches it already captured from the cable, together with the level the host-acknowledge line had while the byte was strobed in. A high level marks a data byte and a low level marks a command byte. Data bytes go to a forward-data FIFO write port. Command bytes go to a separate forward-command FIFO write port.

The block also acts on command bytes. When bit 7 of a command is clear, bits 6:0 hold a repeat count. The next byte, if it is a data byte, is written to the data FIFO count+1 times. When bit 7 is set, bits 6:0 are a channel address. The block latches it into an output register that stays readable until the next such command. While a run is being expanded the block stalls its input. Each copy waits for the data FIFO to be ready, so a slow consumer loses no bytes.

Top module: `ecp_fwd_decoder`

## Requirements
- R1: A byte with `in_hostack`=1, accepted while no run count is pending, appears once and unchanged on the data port. It is presented in the same cycle it is offered, and `in_ready` follows `dat_ready`.
- R2: A byte with `in_hostack`=0 appears once and unchanged on the command port, and it never produces a data-port write. `cmd_valid` and `dat_valid` are never high together.
- R3: Accepting a command byte with bit 7 = 1 loads its bits 6:0 into `chan_addr` on the next clock edge. `chan_addr` changes at no other time.
- R4: Accepting a command byte with bit 7 = 0 arms a run of N = bits 6:0. The next accepted data byte is then written to the data port exactly N+1 times: N=0 gives one copy and N=127 gives 128 copies. The copies start the cycle after that data byte is accepted.
- R5: An armed run is dropped when a channel-address command is accepted before the data byte. A newer run-length command replaces the older count. In both cases no expansion of the old count takes place.
- R6: A run count is used once. The data byte after an expanded byte passes through as a single copy.
- R7: From the cycle after a run's data byte is accepted until the cycle its last copy is accepted, `in_ready` is 0.
- R8: Each copy is held, with `dat_byte` stable, for as long as `dat_ready` is 0. The number of copies is counted in accepted handshakes.
- R9: After reset `dat_valid` and `cmd_valid` are 0 while `in_valid` is 0, `chan_addr` is 0 and no run is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Captured byte is offered |
| in_ready | output | 1 | Block accepts the offered byte |
| in_byte | input | 8 | Captured byte |
| in_hostack | input | 1 | Host-acknowledge level for this byte: 1 data, 0 command |
| dat_valid | output | 1 | Data FIFO write request |
| dat_ready | input | 1 | Data FIFO can take a byte |
| dat_byte | output | 8 | Byte for the data FIFO |
| cmd_valid | output | 1 | Command FIFO write request |
| cmd_ready | input | 1 | Command FIFO can take a byte |
| cmd_byte | output | 8 | Byte for the command FIFO |
| chan_addr | output | 7 | Last channel address received |

## Verification
The bench sweeps every run count from 0 to 127, so an off-by-one in the copy counter gives one copy too many or too few. The two ends show it most clearly: count 0 turning into zero or two copies, and count 127 wrapping the counter. Runs are followed by commands, by newer counts and by a second data byte. A design that keeps a stale count would then multiply a byte that should pass once. Every channel address is loaded in turn. Data-FIFO backpressure is applied in several patterns. A design that decrements without a handshake, or lets a new byte in during a run, loses copies or reorders the stream.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FIELD_W = BYTE_W - 1;

  // command type select sits in the top bit of a command byte
  function automatic logic cmd_is_channel(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  function automatic logic [FIELD_W-1:0] cmd_field(input logic [BYTE_W-1:0] b);
    return b[FIELD_W-1:0];
  endfunction

  // total writes produced by a run count
  function automatic int unsigned run_copies(input logic [FIELD_W-1:0] n);
    return int'(n) + 1;
  endfunction
endpackage

// File: rtl/ecp_byte_classify.sv
module ecp_byte_classify
  import ecp_fwd_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               hostack_i,
  output logic               is_data_o,
  output logic               is_run_cmd_o,
  output logic               is_chan_cmd_o,
  output logic [FIELD_W-1:0] field_o
);
  always_comb begin
    is_data_o     = hostack_i;
    is_run_cmd_o  = !hostack_i && !cmd_is_channel(byte_i);
    is_chan_cmd_o = !hostack_i && cmd_is_channel(byte_i);
    field_o       = cmd_field(byte_i);
  end
endmodule

// File: rtl/ecp_run_expander.sv
module ecp_run_expander
  import ecp_fwd_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned CW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [CW-1:0] arm_cnt_i,
  input  logic          disarm_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_byte_i,
  input  logic          out_ready_i,
  output logic          pending_o,
  output logic          expanding_o,
  output logic          last_copy_o,
  output logic [DW-1:0] held_o
);
  logic          pending_q;
  logic [CW-1:0] cnt_q;
  logic          expanding_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] held_q;

  assign pending_o   = pending_q;
  assign expanding_o = expanding_q;
  assign held_o      = held_q;
  assign last_copy_o = expanding_q && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      cnt_q       <= '0;
      expanding_q <= 1'b0;
      left_q      <= '0;
      held_q      <= '0;
    end else begin
      if (load_i) begin
        pending_q   <= 1'b0;
        expanding_q <= 1'b1;
        left_q      <= cnt_q;
        held_q      <= load_byte_i;
      end else if (expanding_q && out_ready_i) begin
        if (left_q == '0) expanding_q <= 1'b0;
        else              left_q      <= left_q - 1'b1;
      end
      if (arm_i) begin
        pending_q <= 1'b1;
        cnt_q     <= arm_cnt_i;
      end else if (disarm_i) begin
        pending_q <= 1'b0;
      end
    end
  end

  assert_run_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !pending_o);
  assert_run_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (expanding_o && !pending_o));
  assert_last_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_copy_o && out_ready_i) |=> !expanding_o);
  assert_copy_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expanding_o && !out_ready_i) |=> (expanding_o && $stable(held_o)));
endmodule

// File: rtl/ecp_chan_reg.sv
module ecp_chan_reg #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/ecp_fwd_decoder.sv
module ecp_fwd_decoder
  import ecp_fwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic               in_hostack,
  output logic               dat_valid,
  input  logic               dat_ready,
  output logic [BYTE_W-1:0]  dat_byte,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [BYTE_W-1:0]  cmd_byte,
  output logic [FIELD_W-1:0] chan_addr
);
  logic               is_data, is_run_cmd, is_chan_cmd;
  logic [FIELD_W-1:0] field;
  logic               pending, expanding, last_copy;
  logic [BYTE_W-1:0]  held;

  // named events used by the assertions
  logic in_fire, cmd_fire, run_load, run_arm, chan_we;

  ecp_byte_classify cls_i (
    .byte_i(in_byte), .hostack_i(in_hostack),
    .is_data_o(is_data), .is_run_cmd_o(is_run_cmd),
    .is_chan_cmd_o(is_chan_cmd), .field_o(field)
  );

  always_comb begin
    if (expanding)    in_ready = 1'b0;
    else if (is_data) in_ready = pending ? 1'b1 : dat_ready;
    else              in_ready = cmd_ready;
  end

  assign in_fire  = in_valid && in_ready;
  assign cmd_fire = in_fire && !is_data;
  assign run_load = in_fire && is_data && pending;
  assign run_arm  = cmd_fire && is_run_cmd;
  assign chan_we  = cmd_fire && is_chan_cmd;

  assign cmd_valid = in_valid && !is_data && !expanding;
  assign cmd_byte  = in_byte;
  assign dat_valid = expanding || (in_valid && is_data && !pending);
  assign dat_byte  = expanding ? held : in_byte;

  ecp_run_expander #(.DW(BYTE_W), .CW(FIELD_W)) run_i (
    .clk(clk), .rst_n(rst_n),
    .arm_i(run_arm), .arm_cnt_i(field), .disarm_i(chan_we),
    .load_i(run_load), .load_byte_i(in_byte), .out_ready_i(dat_ready),
    .pending_o(pending), .expanding_o(expanding),
    .last_copy_o(last_copy), .held_o(held)
  );

  ecp_chan_reg #(.AW(FIELD_W)) chan_i (
    .clk(clk), .rst_n(rst_n), .we_i(chan_we), .d_i(field), .q_o(chan_addr)
  );

  assert_stall_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expanding |-> !in_ready);
  assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !dat_valid);
  assert_chan_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_we |=> (chan_addr == $past(in_byte[FIELD_W-1:0])));
  assert_copy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_byte)));
  assert_run_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_load |=> (dat_valid && !last_copy || dat_valid));
endmodule

// File: tb/ecp_fwd_decoder_tb_top.sv
module ecp_fwd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       in_hostack = 1'b1;
  logic       dat_valid;
  logic       dat_ready = 1'b1;
  logic [7:0] dat_byte;
  logic       cmd_valid;
  logic       cmd_ready = 1'b1;
  logic [7:0] cmd_byte;
  logic [6:0] chan_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int bp_mode = 0;
  logic running = 1'b0;

  // bench model, built from the requirements
  logic       m_pend = 1'b0;
  int         m_cnt = 0;
  int         m_left = 0;
  logic [7:0] m_held = 8'h00;
  logic [6:0] m_chan = 7'h00;

  always #4 clk = ~clk;

  ecp_fwd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_hostack(in_hostack), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_byte(dat_byte), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_byte(cmd_byte), .chan_addr(chan_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (bp_mode)
      1:       begin dat_ready = (cyc % 3) != 0; cmd_ready = (cyc % 2) == 0; end
      2:       begin dat_ready = (cyc % 5) < 2;  cmd_ready = (cyc % 4) != 1; end
      default: begin dat_ready = 1'b1;           cmd_ready = 1'b1;           end
    endcase
  end

  // monitor: outputs sampled at the falling edge
  always @(negedge clk) begin
    if (running) begin
      automatic bit dat_hs = dat_valid && dat_ready;
      automatic bit in_hs  = in_valid && in_ready;
      chk(chan_addr == m_chan, "R3", chan_addr, m_chan);
      chk(!(cmd_valid && dat_valid), "R2", cmd_valid, 0);
      if (m_left > 0) begin
        chk(!in_ready, "R7", in_ready, 0);
        chk(dat_valid && dat_byte == m_held, "R8", dat_byte, m_held);
        if (dat_hs) begin
          chk(dat_byte == m_held, "R4", dat_byte, m_held);
          m_left = m_left - 1;
        end
      end else if (in_hs && in_hostack) begin
        if (m_pend) begin
          chk(!dat_hs, "R4", dat_hs, 0);
          m_left = m_cnt + 1;
          m_held = in_byte;
          m_pend = 1'b0;
        end else begin
          chk(dat_hs && dat_byte == in_byte, "R1", dat_byte, in_byte);
        end
      end else begin
        chk(!dat_hs, "R6", dat_hs, 0);
        if (in_hs) begin
          chk(cmd_valid && cmd_byte == in_byte, "R2", cmd_byte, in_byte);
          if (in_byte[7]) begin
            m_chan = in_byte[6:0];
            m_pend = 1'b0;
          end else begin
            m_pend = 1'b1;
            m_cnt  = int'(in_byte[6:0]);
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic ha);
    in_valid   = 1'b1;
    in_byte    = b;
    in_hostack = ha;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_left > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!dat_valid && !cmd_valid, "R9", {dat_valid, cmd_valid}, 0);
    chk(chan_addr == 7'h00, "R9", chan_addr, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    running = 1'b1;
    @(negedge clk);
    chk(!dat_valid && !cmd_valid, "R9", {dat_valid, cmd_valid}, 0);
    @(posedge clk);
    #1;

    // R9: after reset no run is armed, so a data byte passes singly
    send(8'h5A, 1'b1);
    drain();

    // R1: plain data under two ready patterns
    for (int i = 0; i < 24; i++) begin
      bp_mode = (i < 12) ? 0 : 2;
      send(8'(i * 13 + 7), 1'b1);
    end
    drain();

    // R4/R8: every run count, with backpressure on odd counts
    for (int n = 0; n < 128; n++) begin
      bp_mode = (n % 2 == 1) ? ((n % 4 == 1) ? 1 : 2) : 0;
      send({1'b0, 7'(n)}, 1'b0);
      send(8'(n) ^ 8'hA5, 1'b1);
    end
    drain();

    // R5: channel command drops an armed run
    bp_mode = 0;
    send(8'h05, 1'b0);
    send(8'hB3, 1'b0);
    send(8'h11, 1'b1);
    // R5: newer count replaces older one
    send(8'h03, 1'b0);
    send(8'h00, 1'b0);
    send(8'h22, 1'b1);
    // R6: count used once
    send(8'h02, 1'b0);
    send(8'h33, 1'b1);
    send(8'h44, 1'b1);
    drain();

    // R3: every channel address
    for (int a = 0; a < 128; a++) begin
      bp_mode = a % 3;
      send({1'b1, 7'(127 - a)}, 1'b0);
    end
    drain();

    // mixed traffic under heavy backpressure
    bp_mode = 2;
    for (int k = 0; k < 16; k++) begin
      send({1'b0, 7'(k * 5)}, 1'b0);
      send(8'(k + 100), 1'b1);
      send(8'(k + 200), 1'b1);
      send({1'b1, 7'(k)}, 1'b0);
    end
    drain();
    running = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule